// File: doc/BRIEF.md
# Handshake GCD Control Sequencer

This block is the control half of a split greatest-common-divisor engine. It holds no operand values. It runs the subtract-until-equal algorithm only by issuing requests to a separate datapath and waiting for the matching acknowledgements. Each cycle of the algorithm has the same steps. Both operand registers are loaded together. A compare is then requested, and the datapath answers with one of three verdicts: above, equal or below. The sequencer reacts to the verdict in one of two ways. On an above or below verdict it asks the datapath to reduce the larger operand and then compares again. On an equal verdict it offers the result to a consumer and, once the consumer has taken it, loads a fresh pair.

Every request follows a four-phase protocol. The controller is clocked. All incoming acknowledgements pass through a synchroniser whose depth is a parameter, so the datapath and the consumer may be timed independently of the controller clock. When two or more verdict lines are high together, the sequencer enters a sticky error state and issues nothing until it is reset.

Top module: `gcd_hs_ctrl`

## Requirements
- R1: While reset is asserted, every request output and the error output are low. After reset is released, both load requests rise within three clock cycles.
- R2: Every request follows the four-phase protocol:
  - A request rises only while its acknowledgement is low.
  - It stays high until that acknowledgement is seen high, and only then falls.
  - It is not raised again until the acknowledgement has returned low.
- R3: The two load requests rise in the same cycle. The compare request rises only after both load handshakes have fully completed, with both load requests and both load acknowledgements low.
- R4: After an above verdict, the next request is reduce-A (A := A - B). Its handshake completes on the A-register acknowledgement (`opa_ld_ack_i`), and a new compare follows.
- R5: After a below verdict, the next request is reduce-B (B := B - A). Its handshake completes on the B-register acknowledgement (`opb_ld_ack_i`), and a new compare follows.
- R6: After an equal verdict, the next request is the result request. When its handshake completes, a new pair of load requests follows. The datapath then holds the GCD of the loaded pair in both registers, after exactly the number of reductions that the subtract algorithm needs.
- R7: If more than one of `cmp_gt_i`, `cmp_eq_i` and `cmp_lt_i` is high when a compare acknowledgement is taken, `proto_err_o` goes high. It stays high, and all requests stay low, until reset.
- R8: At most one of the compare, reduce-A, reduce-B and result requests is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opa_ld_req_o | output | 1 | Request: load operand A from the input |
| opa_ld_ack_i | input | 1 | A-register write acknowledge (load or reduce) |
| opb_ld_req_o | output | 1 | Request: load operand B from the input |
| opb_ld_ack_i | input | 1 | B-register write acknowledge (load or reduce) |
| cmp_req_o | output | 1 | Request: compare A with B |
| cmp_gt_i | input | 1 | Verdict acknowledge: A above B |
| cmp_eq_i | input | 1 | Verdict acknowledge: A equal to B |
| cmp_lt_i | input | 1 | Verdict acknowledge: A below B |
| dec_a_req_o | output | 1 | Request: A := A - B |
| dec_b_req_o | output | 1 | Request: B := B - A |
| res_req_o | output | 1 | Request: result valid for the consumer |
| res_ack_i | input | 1 | Consumer acknowledge of the result |
| proto_err_o | output | 1 | Sticky flag for conflicting verdicts |

## Verification
A wrong sequencer state shows up at the ports on the first request edge that follows it. That edge can be a compare issued before a load has finished, a reduce in the wrong direction, or a result request after a verdict other than equal. The bench flags it at that edge by comparing against the last verdict it produced itself. A wrong branch that escapes the edge checks still leaves the modelled registers holding the wrong value or the wrong reduction count when the result is requested. A channel stuck in the wrong phase either drops a request before its acknowledgement arrives, which is flagged on that cycle, or stops the loop entirely, which the watchdog catches.

// File: rtl/gcd_hs_pkg.sv
package gcd_hs_pkg;

  typedef enum logic [2:0] {
    SQ_LOAD,
    SQ_LOAD_W,
    SQ_CMP,
    SQ_CMP_W,
    SQ_SUB_W,
    SQ_RES_W,
    SQ_ERR
  } seq_st_e;

  typedef enum logic [1:0] {
    VD_NONE,
    VD_GT,
    VD_EQ,
    VD_LT
  } verdict_e;

  typedef enum logic [1:0] {
    CH_IDLE,
    CH_REQ,
    CH_RTZ
  } chan_st_e;

endpackage

// File: rtl/gcd_hs_sync.sv
module gcd_hs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_ff
      logic [WIDTH-1:0] pipe_q [STAGES];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= '0;
        end else begin
          pipe_q[0] <= d_i;
          for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
        end
      end

      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/gcd_hs_chan.sv
module gcd_hs_chan
  import gcd_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);

  chan_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CH_IDLE: if (start_i) st_d = CH_REQ;
      CH_REQ:  if (ack_i)   st_d = CH_RTZ;
      CH_RTZ:  if (!ack_i)  st_d = CH_IDLE;
      default:              st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CH_IDLE;
    else         st_q <= st_d;
  end

  assign req_o  = (st_q == CH_REQ);
  assign done_o = (st_q == CH_RTZ) && !ack_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o); // R2

  AST_NO_EARLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && ack_i) |=> !req_o); // R2

  AST_START_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!req_o && !ack_i)); // R2

endmodule

// File: rtl/gcd_hs_ctrl.sv
module gcd_hs_ctrl
  import gcd_hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic opa_ld_req_o,
  input  logic opa_ld_ack_i,
  output logic opb_ld_req_o,
  input  logic opb_ld_ack_i,
  output logic cmp_req_o,
  input  logic cmp_gt_i,
  input  logic cmp_eq_i,
  input  logic cmp_lt_i,
  output logic dec_a_req_o,
  output logic dec_b_req_o,
  output logic res_req_o,
  input  logic res_ack_i,
  output logic proto_err_o
);

  localparam int unsigned N_ACK  = 6;
  localparam int unsigned N_CH   = 6;
  localparam int unsigned AK_A   = 0;
  localparam int unsigned AK_B   = 1;
  localparam int unsigned AK_GT  = 2;
  localparam int unsigned AK_EQ  = 3;
  localparam int unsigned AK_LT  = 4;
  localparam int unsigned AK_RES = 5;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
  localparam int unsigned CH_CMP = 2;
  localparam int unsigned CH_DA  = 3;
  localparam int unsigned CH_DB  = 4;
  localparam int unsigned CH_RES = 5;

  logic [N_ACK-1:0] ack_raw, ack_s;
  logic [N_CH-1:0]  start_v, ack_v, req_v, done_v;
  logic             vd_any, vd_multi, cmp_hit;

  assign ack_raw = {res_ack_i, cmp_lt_i, cmp_eq_i, cmp_gt_i, opb_ld_ack_i, opa_ld_ack_i};

  gcd_hs_sync #(.WIDTH(N_ACK), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_raw),
    .q_o    (ack_s)
  );

  assign vd_any   = ack_s[AK_GT] | ack_s[AK_EQ] | ack_s[AK_LT];
  assign vd_multi = (ack_s[AK_GT] & ack_s[AK_EQ]) | (ack_s[AK_GT] & ack_s[AK_LT]) |
                    (ack_s[AK_EQ] & ack_s[AK_LT]);

  // reduce steps complete on the register write of the operand they change
  always_comb begin
    ack_v         = '0;
    ack_v[CH_A]   = ack_s[AK_A];
    ack_v[CH_B]   = ack_s[AK_B];
    ack_v[CH_CMP] = vd_any;
    ack_v[CH_DA]  = ack_s[AK_A];
    ack_v[CH_DB]  = ack_s[AK_B];
    ack_v[CH_RES] = ack_s[AK_RES];
  end

  generate
    for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
      gcd_hs_chan u_chan (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_v[c]),
        .ack_i   (ack_v[c]),
        .req_o   (req_v[c]),
        .done_o  (done_v[c])
      );
    end
  endgenerate

  assign opa_ld_req_o = req_v[CH_A];
  assign opb_ld_req_o = req_v[CH_B];
  assign cmp_req_o    = req_v[CH_CMP];
  assign dec_a_req_o  = req_v[CH_DA];
  assign dec_b_req_o  = req_v[CH_DB];
  assign res_req_o    = req_v[CH_RES];

  assign cmp_hit = req_v[CH_CMP] & vd_any;

  seq_st_e    st_q, st_d;
  verdict_e   vd_q, vd_d;
  logic [1:0] ld_q, ld_d;

  always_comb begin
    st_d    = st_q;
    vd_d    = vd_q;
    ld_d    = ld_q;
    start_v = '0;
    unique case (st_q)
      SQ_LOAD: begin
        start_v[CH_A] = 1'b1;
        start_v[CH_B] = 1'b1;
        ld_d          = 2'b00;
        st_d          = SQ_LOAD_W;
      end
      SQ_LOAD_W: begin
        ld_d = ld_q | {done_v[CH_B], done_v[CH_A]};
        if (&ld_d) st_d = SQ_CMP;
      end
      SQ_CMP: begin
        start_v[CH_CMP] = 1'b1;
        vd_d            = VD_NONE;
        st_d            = SQ_CMP_W;
      end
      SQ_CMP_W: begin
        if (cmp_hit) begin
          if (vd_multi)          st_d = SQ_ERR;
          else if (ack_s[AK_GT]) vd_d = VD_GT;
          else if (ack_s[AK_LT]) vd_d = VD_LT;
          else                   vd_d = VD_EQ;
        end else if (done_v[CH_CMP]) begin
          unique case (vd_q)
            VD_GT: begin start_v[CH_DA]  = 1'b1; st_d = SQ_SUB_W; end
            VD_LT: begin start_v[CH_DB]  = 1'b1; st_d = SQ_SUB_W; end
            VD_EQ: begin start_v[CH_RES] = 1'b1; st_d = SQ_RES_W; end
            default: st_d = SQ_ERR;
          endcase
        end
      end
      SQ_SUB_W: if (done_v[CH_DA] | done_v[CH_DB]) st_d = SQ_CMP;
      SQ_RES_W: if (done_v[CH_RES]) st_d = SQ_LOAD;
      SQ_ERR:   st_d = SQ_ERR;
      default:  st_d = SQ_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_LOAD;
      vd_q <= VD_NONE;
      ld_q <= 2'b00;
    end else begin
      st_q <= st_d;
      vd_q <= vd_d;
      ld_q <= ld_d;
    end
  end

  assign proto_err_o = (st_q == SQ_ERR);

  AST_LOADS_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(opa_ld_req_o) |-> opb_ld_req_o); // R3

  AST_CMP_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_req_o) |-> (!opa_ld_req_o && !opb_ld_req_o && !ack_s[AK_A] && !ack_s[AK_B])); // R3

  AST_DEC_A_ON_GT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_a_req_o) |-> (vd_q == VD_GT)); // R4

  AST_DEC_B_ON_LT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_b_req_o) |-> (vd_q == VD_LT)); // R5

  AST_RES_ON_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_req_o) |-> (vd_q == VD_EQ)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o); // R7

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (req_v == '0)); // R7

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmp_req_o, dec_a_req_o, dec_b_req_o, res_req_o})); // R8

endmodule

// File: tb/gcd_hs_ctrl_test.sv
module gcd_hs_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opa_ld_req, opb_ld_req, cmp_req, dec_a_req, dec_b_req, res_req, proto_err;
  logic ack_a = 1'b0, ack_b = 1'b0, vd_gt = 1'b0, vd_eq = 1'b0, vd_lt = 1'b0, ack_r = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcd_hs_ctrl uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .opa_ld_req_o (opa_ld_req),
    .opa_ld_ack_i (ack_a),
    .opb_ld_req_o (opb_ld_req),
    .opb_ld_ack_i (ack_b),
    .cmp_req_o    (cmp_req),
    .cmp_gt_i     (vd_gt),
    .cmp_eq_i     (vd_eq),
    .cmp_lt_i     (vd_lt),
    .dec_a_req_o  (dec_a_req),
    .dec_b_req_o  (dec_b_req),
    .res_req_o    (res_req),
    .res_ack_i    (ack_r),
    .proto_err_o  (proto_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int qa[$], qb[$], qe[$], qs[$];
  int a_val = 0, b_val = 0, subs = 0, last_vd = 0;
  int cnt_a = 0, cnt_b = 0, cnt_c = 0, cnt_r = 0;
  bit inject = 1'b0;
  logic p_la, p_lb, p_c, p_da, p_db, p_r, p_aa, p_ab, p_av, p_ar;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // driver: operands to the datapath model, expected result to the scoreboard
  task automatic push_pair(input int a, input int b);
    int x = a, y = b, n = 0;
    while (x != y) begin
      if (x > y) x -= y; else y -= x;
      n++;
    end
    qa.push_back(a); qb.push_back(b); qe.push_back(x); qs.push_back(n);
  endtask

  function automatic int reqs();
    return int'({opa_ld_req, opb_ld_req, cmp_req, dec_a_req, dec_b_req, res_req});
  endfunction

  // datapath model and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ack_a = 0; ack_b = 0; vd_gt = 0; vd_eq = 0; vd_lt = 0; ack_r = 0;
        cnt_a = 0; cnt_b = 0; cnt_c = 0; cnt_r = 0;
        {p_la, p_lb, p_c, p_da, p_db, p_r, p_aa, p_ab, p_av, p_ar} = '0;
      end else begin
        if (opa_ld_req && !p_la) begin
          chk(opb_ld_req, "R3", "load B with load A", int'(opb_ld_req), 1);
          chk(!p_aa, "R2", "A ack low at load rise", int'(p_aa), 0);
        end
        if (opb_ld_req && !p_lb) chk(opa_ld_req, "R3", "load A with load B", int'(opa_ld_req), 1);
        if (cmp_req && !p_c) begin
          chk(!opa_ld_req && !opb_ld_req && !p_aa && !p_ab, "R3", "compare after loads",
              reqs(), 8);
          chk(!p_av, "R2", "verdicts low at compare rise", int'(p_av), 0);
        end
        if (dec_a_req && !p_da) chk(last_vd == 1, "R4", "reduce-A after above", last_vd, 1);
        if (dec_b_req && !p_db) chk(last_vd == 3, "R5", "reduce-B after below", last_vd, 3);
        if (res_req && !p_r)    chk(last_vd == 2, "R6", "result after equal", last_vd, 2);
        if ((cmp_req && !p_c) || (dec_a_req && !p_da) || (dec_b_req && !p_db) || (res_req && !p_r))
          chk($countones({cmp_req, dec_a_req, dec_b_req, res_req}) <= 1, "R8", "single step request",
              $countones({cmp_req, dec_a_req, dec_b_req, res_req}), 1);
        if ((p_la && !opa_ld_req) || (p_da && !dec_a_req))
          chk(p_aa, "R2", "A-side request fell before ack", int'(p_aa), 1);
        if ((p_lb && !opb_ld_req) || (p_db && !dec_b_req))
          chk(p_ab, "R2", "B-side request fell before ack", int'(p_ab), 1);
        if (p_c && !cmp_req) chk(p_av, "R2", "compare fell before verdict", int'(p_av), 1);
        if (p_r && !res_req) chk(p_ar, "R2", "result fell before ack", int'(p_ar), 1);

        // A register
        if ((opa_ld_req || dec_a_req) && !ack_a) begin
          if (dec_a_req || qa.size() > 0) begin
            cnt_a++;
            if (cnt_a >= 1) begin
              if (opa_ld_req) begin a_val = qa.pop_front(); subs = 0; end
              else begin a_val -= b_val; subs++; end
              ack_a = 1; cnt_a = 0;
            end
          end
        end else if (!opa_ld_req && !dec_a_req) ack_a = 0;
        // B register
        if ((opb_ld_req || dec_b_req) && !ack_b) begin
          if (dec_b_req || qb.size() > 0) begin
            cnt_b++;
            if (cnt_b >= 4) begin
              if (opb_ld_req) b_val = qb.pop_front();
              else begin b_val -= a_val; subs++; end
              ack_b = 1; cnt_b = 0;
            end
          end
        end else if (!opb_ld_req && !dec_b_req) ack_b = 0;
        // comparator
        if (cmp_req && !(vd_gt || vd_eq || vd_lt)) begin
          cnt_c++;
          if (cnt_c >= 2) begin
            cnt_c = 0;
            if (inject) begin vd_gt = 1; vd_eq = 1; inject = 0; last_vd = 0; end
            else if (a_val > b_val) begin vd_gt = 1; last_vd = 1; end
            else if (a_val < b_val) begin vd_lt = 1; last_vd = 3; end
            else begin vd_eq = 1; last_vd = 2; end
          end
        end else if (!cmp_req) begin vd_gt = 0; vd_eq = 0; vd_lt = 0; end
        // consumer with scoreboard
        if (res_req && !ack_r) begin
          cnt_r++;
          if (cnt_r >= 2) begin
            cnt_r = 0; ack_r = 1;
            if (qe.size() == 0) chk(0, "R6", "unexpected result", a_val, -1);
            else begin
              int e, s;
              e = qe.pop_front(); s = qs.pop_front();
              chk(a_val == e, "R6", "A holds GCD", a_val, e);
              chk(b_val == e, "R6", "B holds GCD", b_val, e);
              chk(subs == s, "R4", "reduction count (R5 too)", subs, s);
            end
          end
        end else if (!res_req) ack_r = 0;

        p_la = opa_ld_req; p_lb = opb_ld_req; p_c = cmp_req; p_da = dec_a_req;
        p_db = dec_b_req; p_r = res_req; p_aa = ack_a; p_ab = ack_b;
        p_av = vd_gt | vd_eq | vd_lt; p_ar = ack_r;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1: watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit quiet;
    repeat (3) @(negedge clk);
    chk(reqs() == 0, "R1", "requests low in reset", reqs(), 0);
    chk(!proto_err, "R1", "error low in reset", int'(proto_err), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(opa_ld_req && opb_ld_req, "R1", "loads raised after reset", reqs(), 48);

    push_pair(12, 18);
    push_pair(7, 7);
    push_pair(1, 200);
    push_pair(255, 2);
    push_pair(100, 75);
    push_pair(64, 24);
    while (qe.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(opa_ld_req && opb_ld_req, "R6", "new load after result", reqs(), 48);

    inject = 1;
    qa.push_back(9); qb.push_back(3);
    for (int i = 0; i < 100 && !proto_err; i++) @(negedge clk);
    chk(proto_err, "R7", "error on conflicting verdicts", int'(proto_err), 1);
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (reqs() != 0 || !proto_err) quiet = 0;
    end
    chk(quiet, "R7", "error sticky and requests low", reqs(), 0);

    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(reqs() == 0 && !proto_err, "R1", "reset clears error", reqs() + int'(proto_err), 0);
    rst_n = 1;
    push_pair(5, 15);
    while (qe.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(!proto_err, "R7", "no error after recovery", int'(proto_err), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule